// File: doc/BRIEF.md
# Machine and Supervisor Trap CSR File

This block holds the 64-bit trap-related control and status registers of a RISC-V hart and runs the six CSR read-modify-write operations on them. Each operation gives a 12-bit register address, a 3-bit operation code and a source value. The source is either a 64-bit register operand or the 5-bit field from the instruction, zero-extended. In the same cycle the block returns the register's current contents for the destination register. The new value is stored on the next rising clock edge.

The supervisor interrupt-enable address has no storage of its own. It is a window onto the machine interrupt-enable register, masked by the interrupt-delegation register, for both reads and writes. Every other implemented address has a plain 64-bit register. Addresses that are not implemented read as zero and drop writes. Privilege checks and illegal-instruction reporting belong to the surrounding pipeline.

Top module: `csr_unit`

## Requirements
- R1: After reset, every implemented register reads as zero.
- R2: Operation code 001 (register write) returns the old value on `rdData` in the same cycle and stores `srcOperand`. The stored value is visible from the next cycle onward.
- R3: Operation code 010 ORs `srcOperand` into the register. Operation code 011 clears the register bits that are set in `srcOperand`.
- R4: Operation codes 101, 110 and 111 behave like 001, 010 and 011, but use `srcIdx` zero-extended to 64 bits as the source.
- R5: A set or clear operation (010, 011, 110, 111) with `srcIdx` equal to 0 stores nothing. A write operation (001, 101) stores even when `srcIdx` is 0.
- R6: A read of address 0x104 returns the register at 0x304 ANDed with the register at 0x303.
- R7: A write to address 0x104 changes only those bits of the 0x304 register that are set in the 0x303 register. All other bits of 0x304 keep their value.
- R8: Addresses outside the implemented set read as zero and ignore writes. Operation codes 000 and 100, and cycles with `opValid` low, store nothing.
- R9: The implemented addresses 0x100, 0x105, 0x141, 0x142, 0x143, 0x144, 0x180, 0x300, 0x302, 0x303, 0x304, 0x305, 0x341, 0x342, 0x343 and 0x344 each have their own storage. A write to one of them leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Strobe: a CSR operation is presented this cycle |
| funct3 | input | 3 | Operation code |
| csrAddr | input | 12 | CSR address |
| srcOperand | input | 64 | Register source value |
| srcIdx | input | 5 | Source register index, or the immediate in immediate forms |
| rdData | output | 64 | Register contents before the update |

## Verification
`rdData` depends combinationally on the presented operation, so the bench drives each operation just after a falling edge and samples `rdData` one time unit later, before the rising edge that stores the result. The effect of a store is therefore checked on the next operation, one cycle later, against a bench model that is updated only after that edge. The bench gives no credit for a write until a later operation reads the value back. This is how the aliased enable window, suppressed writes and unmapped addresses are all observed at the ports.

// File: rtl/csr_pkg.sv
package csr_pkg;

  localparam int XLEN_DEF   = 64;
  localparam int ADDR_W_DEF = 12;
  localparam int IMM_W      = 5;

  // physical storage slots; the supervisor enable window has no slot
  localparam int NUM_SLOTS = 16;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  localparam logic [SLOT_W-1:0] SLOT_SSTAT  = 4'd0;
  localparam logic [SLOT_W-1:0] SLOT_STVEC  = 4'd1;
  localparam logic [SLOT_W-1:0] SLOT_SEPC   = 4'd2;
  localparam logic [SLOT_W-1:0] SLOT_SCAUSE = 4'd3;
  localparam logic [SLOT_W-1:0] SLOT_STVAL  = 4'd4;
  localparam logic [SLOT_W-1:0] SLOT_SPEND  = 4'd5;
  localparam logic [SLOT_W-1:0] SLOT_XLAT   = 4'd6;
  localparam logic [SLOT_W-1:0] SLOT_MSTAT  = 4'd7;
  localparam logic [SLOT_W-1:0] SLOT_EXDLG  = 4'd8;
  localparam logic [SLOT_W-1:0] SLOT_IRQDLG = 4'd9;
  localparam logic [SLOT_W-1:0] SLOT_MENAB  = 4'd10;
  localparam logic [SLOT_W-1:0] SLOT_MTVEC  = 4'd11;
  localparam logic [SLOT_W-1:0] SLOT_MEPC   = 4'd12;
  localparam logic [SLOT_W-1:0] SLOT_MCAUSE = 4'd13;
  localparam logic [SLOT_W-1:0] SLOT_MTVAL  = 4'd14;
  localparam logic [SLOT_W-1:0] SLOT_MPEND  = 4'd15;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RW   = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              wrEn;
    logic              useImm;
    opKind_e           opKind;
    logic              hit;
    logic              sieView;
    logic [SLOT_W-1:0] slot;
  } csrStrobe_t;

endpackage

// File: rtl/csr_ctrl.sv
module csr_ctrl
  import csr_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF
) (
  input  logic              opValid,
  input  logic [2:0]        funct3,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [IMM_W-1:0]  srcIdx,
  output csrStrobe_t        strobe
);

  logic              addrHit;
  logic              addrSie;
  logic [SLOT_W-1:0] addrSlot;
  opKind_e           kind;
  logic              immForm;
  logic              zeroSrc;

  // address decode: map the sparse CSR space onto dense slots
  always_comb begin
    addrHit  = 1'b1;
    addrSie  = 1'b0;
    addrSlot = SLOT_SSTAT;
    unique case (csrAddr)
      12'h100: addrSlot = SLOT_SSTAT;
      12'h104: begin addrSlot = SLOT_MENAB; addrSie = 1'b1; end
      12'h105: addrSlot = SLOT_STVEC;
      12'h141: addrSlot = SLOT_SEPC;
      12'h142: addrSlot = SLOT_SCAUSE;
      12'h143: addrSlot = SLOT_STVAL;
      12'h144: addrSlot = SLOT_SPEND;
      12'h180: addrSlot = SLOT_XLAT;
      12'h300: addrSlot = SLOT_MSTAT;
      12'h302: addrSlot = SLOT_EXDLG;
      12'h303: addrSlot = SLOT_IRQDLG;
      12'h304: addrSlot = SLOT_MENAB;
      12'h305: addrSlot = SLOT_MTVEC;
      12'h341: addrSlot = SLOT_MEPC;
      12'h342: addrSlot = SLOT_MCAUSE;
      12'h343: addrSlot = SLOT_MTVAL;
      12'h344: addrSlot = SLOT_MPEND;
      default: addrHit  = 1'b0;
    endcase
  end

  // operation decode
  always_comb begin
    immForm = funct3[2];
    unique case (funct3[1:0])
      2'b01:   kind = OP_RW;
      2'b10:   kind = OP_SET;
      2'b11:   kind = OP_CLR;
      default: kind = OP_NONE;
    endcase
  end

  assign zeroSrc = (srcIdx == '0);

  always_comb begin
    strobe.useImm  = immForm;
    strobe.opKind  = kind;
    strobe.hit     = addrHit;
    strobe.sieView = addrSie;
    strobe.slot    = addrSlot;
    strobe.wrEn    = opValid && addrHit &&
                     ((kind == OP_RW) ||
                      (((kind == OP_SET) || (kind == OP_CLR)) && !zeroSrc));
  end

endmodule

// File: rtl/csr_dpath.sv
module csr_dpath
  import csr_pkg::*;
#(
  parameter int XLEN = XLEN_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  csrStrobe_t       strobe,
  input  logic [XLEN-1:0]  srcOperand,
  input  logic [IMM_W-1:0] srcIdx,
  output logic [XLEN-1:0]  rdData,
  output logic [XLEN-1:0]  mieQ,
  output logic [XLEN-1:0]  midelegQ
);

  logic [XLEN-1:0] regQ    [NUM_SLOTS];
  logic [XLEN-1:0] regNext [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slotWr;
  logic [XLEN-1:0] srcVal;
  logic [XLEN-1:0] oldVal;
  logic [XLEN-1:0] newVal;

  assign mieQ     = regQ[SLOT_MENAB];
  assign midelegQ = regQ[SLOT_IRQDLG];

  assign srcVal = strobe.useImm ? {{(XLEN-IMM_W){1'b0}}, srcIdx} : srcOperand;

  // read path, including the masked enable window
  always_comb begin
    if (!strobe.hit)
      oldVal = '0;
    else if (strobe.sieView)
      oldVal = mieQ & midelegQ;
    else
      oldVal = regQ[strobe.slot];
  end

  assign rdData = oldVal;

  always_comb begin
    unique case (strobe.opKind)
      OP_RW:   newVal = srcVal;
      OP_SET:  newVal = oldVal | srcVal;
      OP_CLR:  newVal = oldVal & ~srcVal;
      default: newVal = oldVal;
    endcase
  end

  // per-slot enables and next values
  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      slotWr[i]  = strobe.wrEn && (strobe.slot == SLOT_W'(i));
      regNext[i] = newVal;
    end
    if (strobe.sieView)
      regNext[SLOT_MENAB] = (mieQ & ~midelegQ) | (newVal & midelegQ);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!rstN)
        regQ[i] <= '0;
      else if (slotWr[i])
        regQ[i] <= regNext[i];
    end
  end

endmodule

// File: rtl/csr_unit.sv
module csr_unit
  import csr_pkg::*;
#(
  parameter int XLEN   = XLEN_DEF,
  parameter int ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        funct3,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [XLEN-1:0]   srcOperand,
  input  logic [IMM_W-1:0]  srcIdx,
  output logic [XLEN-1:0]   rdData
);

  csrStrobe_t      strobe;
  logic [XLEN-1:0] mieQ;
  logic [XLEN-1:0] midelegQ;

  csr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .opValid (opValid),
    .funct3  (funct3),
    .csrAddr (csrAddr),
    .srcIdx  (srcIdx),
    .strobe  (strobe)
  );

  csr_dpath #(.XLEN(XLEN)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .srcOperand (srcOperand),
    .srcIdx     (srcIdx),
    .rdData     (rdData),
    .mieQ       (mieQ),
    .midelegQ   (midelegQ)
  );

endmodule

// File: rtl/csr_unit_chk.sv
module csr_unit_chk #(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [2:0]        funct3,
  input logic [ADDR_W-1:0] csrAddr,
  input logic [XLEN-1:0]   srcOperand,
  input logic [4:0]        srcIdx,
  input logic [XLEN-1:0]   rdData,
  input logic [XLEN-1:0]   mieQ,
  input logic [XLEN-1:0]   midelegQ
);

  function automatic logic known(input logic [ADDR_W-1:0] a);
    case (a)
      12'h100, 12'h104, 12'h105, 12'h141, 12'h142, 12'h143, 12'h144,
      12'h180, 12'h300, 12'h302, 12'h303, 12'h304, 12'h305, 12'h341,
      12'h342, 12'h343, 12'h344: known = 1'b1;
      default: known = 1'b0;
    endcase
  endfunction

  logic zeroSetClr;
  assign zeroSetClr = opValid && (srcIdx == 5'd0) &&
                      (funct3[1:0] == 2'b10 || funct3[1:0] == 2'b11);

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !known(csrAddr)) |-> (rdData == '0)); // R8

  AST_RW_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && funct3 == 3'b001 && csrAddr == 12'h341) |=>
    (!(opValid && csrAddr == 12'h341) || rdData == $past(srcOperand))); // R2

  AST_ZERO_SRC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (zeroSetClr && csrAddr == 12'h341) |=>
    (!(opValid && csrAddr == 12'h341) || rdData == $past(rdData))); // R5

  AST_SIE_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && csrAddr == 12'h104) |-> (rdData == (mieQ & midelegQ))); // R6

  AST_SIE_KEEPS_LOCAL: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && csrAddr == 12'h104) |=>
    ((mieQ & ~midelegQ) == $past(mieQ & ~midelegQ))); // R7

endmodule

bind csr_unit csr_unit_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .opValid    (opValid),
  .funct3     (funct3),
  .csrAddr    (csrAddr),
  .srcOperand (srcOperand),
  .srcIdx     (srcIdx),
  .rdData     (rdData),
  .mieQ       (mieQ),
  .midelegQ   (midelegQ)
);

// File: tb/tb_csr_unit.sv
module tb_csr_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  funct3 = '0;
  logic [11:0] csrAddr = '0;
  logic [63:0] srcOperand = '0;
  logic [4:0]  srcIdx = '0;
  logic [63:0] rdData;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [63:0] model [16];

  localparam logic [11:0] ADDRS [16] = '{
    12'h100, 12'h105, 12'h141, 12'h142, 12'h143, 12'h144, 12'h180, 12'h300,
    12'h302, 12'h303, 12'h304, 12'h305, 12'h341, 12'h342, 12'h343, 12'h344};

  csr_unit dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .funct3(funct3),
    .csrAddr(csrAddr), .srcOperand(srcOperand), .srcIdx(srcIdx),
    .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int slotOf(input logic [11:0] a);
    for (int i = 0; i < 16; i++) if (ADDRS[i] == a) return i;
    return -1;
  endfunction

  function automatic logic [63:0] expRead(input logic [11:0] a);
    if (a == 12'h104) return model[10] & model[9];
    if (slotOf(a) < 0) return '0;
    return model[slotOf(a)];
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one operation: drive after falling edge, sample before rising edge
  task automatic op(input string tag, input logic v, input logic [2:0] f3,
                    input logic [11:0] a, input logic [63:0] opnd, input logic [4:0] idx);
    logic [63:0] src, old, nv;
    bit doWr;
    @(negedge clk);
    opValid = v; funct3 = f3; csrAddr = a; srcOperand = opnd; srcIdx = idx;
    #1;
    old = expRead(a);
    if (v) check(tag, rdData, old);
    src = f3[2] ? {59'd0, idx} : opnd;
    doWr = 0; nv = old;
    case (f3[1:0])
      2'b01: begin doWr = 1; nv = src; end
      2'b10: begin doWr = (idx != 0); nv = old | src; end
      2'b11: begin doWr = (idx != 0); nv = old & ~src; end
      default: doWr = 0;
    endcase
    @(posedge clk);
    if (v && doWr) begin
      if (a == 12'h104) model[10] = (model[10] & ~model[9]) | (nv & model[9]);
      else if (slotOf(a) >= 0) model[slotOf(a)] = nv;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset values, read with a no-write set
    for (int i = 0; i < 16; i++) op("R1", 1, 3'b010, ADDRS[i], 64'hFFFF, 5'd0);
    op("R1", 1, 3'b010, 12'h104, 64'h0, 5'd0);

    // R2: write returns old, new value visible next op
    op("R2", 1, 3'b001, 12'h341, 64'hDEAD_BEEF_0123_4567, 5'd3);
    op("R2", 1, 3'b001, 12'h341, 64'h1111_2222_3333_4444, 5'd3);
    op("R2", 1, 3'b010, 12'h341, 64'h0, 5'd0);
    check("R2", rdData, 64'h1111_2222_3333_4444);

    // R3: set and clear
    op("R3", 1, 3'b001, 12'h300, 64'h00F0, 5'd1);
    op("R3", 1, 3'b010, 12'h300, 64'h0F0F, 5'd1);
    op("R3", 1, 3'b011, 12'h300, 64'h00FF, 5'd1);
    op("R3", 1, 3'b010, 12'h300, 64'h0, 5'd0);
    check("R3", rdData, 64'h0F00);

    // R4: immediate forms
    op("R4", 1, 3'b101, 12'h305, 64'hFFFF_FFFF, 5'd17);
    op("R4", 1, 3'b110, 12'h305, 64'hFFFF_FFFF, 5'd6);
    op("R4", 1, 3'b111, 12'h305, 64'hFFFF_FFFF, 5'd1);
    op("R4", 1, 3'b110, 12'h305, 64'h0, 5'd0);
    check("R4", rdData, 64'd22);

    // R5: zero source suppresses set/clear but not write
    op("R5", 1, 3'b011, 12'h305, 64'hFFFF, 5'd0);
    op("R5", 1, 3'b111, 12'h305, 64'h0, 5'd0);
    op("R5", 1, 3'b010, 12'h305, 64'h0, 5'd0);
    check("R5", rdData, 64'd22);
    op("R5", 1, 3'b101, 12'h305, 64'hAAAA, 5'd0);
    op("R5", 1, 3'b010, 12'h305, 64'h0, 5'd0);
    check("R5", rdData, 64'd0);

    // R6 R7: masked enable window
    op("R6", 1, 3'b001, 12'h304, 64'hFF00_00FF, 5'd2);
    op("R6", 1, 3'b001, 12'h303, 64'h0F0F_0F0F, 5'd2);
    op("R6", 1, 3'b010, 12'h104, 64'h0, 5'd0);
    check("R6", rdData, 64'h0F00_000F);
    op("R7", 1, 3'b001, 12'h104, 64'hFFFF_FFFF_0000_0000, 5'd2);
    op("R7", 1, 3'b010, 12'h304, 64'h0, 5'd0);
    check("R7", rdData, 64'hF000_00F0);
    op("R7", 1, 3'b010, 12'h104, 64'h0000_0000_0000_0F00, 5'd4);
    op("R7", 1, 3'b010, 12'h304, 64'h0, 5'd0);
    check("R7", rdData, 64'hF000_0FF0);

    // R8: unmapped, invalid codes, no strobe
    op("R8", 1, 3'b001, 12'h340, 64'h1234, 5'd1);
    op("R8", 1, 3'b010, 12'h340, 64'h0, 5'd0);
    op("R8", 1, 3'b000, 12'h341, 64'h5555, 5'd9);
    op("R8", 1, 3'b100, 12'h341, 64'h5555, 5'd9);
    op("R8", 0, 3'b001, 12'h341, 64'h7777, 5'd9);
    op("R8", 1, 3'b010, 12'h341, 64'h0, 5'd0);
    check("R8", rdData, 64'h1111_2222_3333_4444);

    // R9: isolation, write each then read all
    for (int i = 0; i < 16; i++)
      op("R9", 1, 3'b001, ADDRS[i], {48'h0, 4'(i), 12'hABC}, 5'd1);
    for (int i = 0; i < 16; i++) op("R9", 1, 3'b010, ADDRS[i], 64'h0, 5'd0);

    // random mix (R2 R3 R4 R5 R7 R8)
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      logic [2:0] f3;
      int pick = $urandom_range(0, 19);
      if (pick < 16) a = ADDRS[pick];
      else if (pick < 18) a = 12'h104;
      else a = 12'($urandom_range(0, 4095));
      f3 = 3'($urandom_range(0, 7));
      op("Rrand_R3", 1, f3, a, {$urandom, $urandom}, 5'($urandom_range(0, 3) == 0 ? 0 : $urandom_range(0, 31)));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule